// File: doc/BRIEF.md
# Hierarchical Clock-Enable Divider

This block derives a set of clock-enable strobes from one fast reference clock. It does not gate or switch any clock. Each derived domain gets a strobe that is high for one reference cycle in every period of that domain. Logic in the domain advances only on cycles where its strobe is high.

The domains form a cascade. A main strobe comes first. By default it is high on every reference cycle; in self-test mode it is divided by a programmable ratio. A copy of the main strobe follows it two cycles later. A host divider counts main ticks. Three peripheral dividers count host ticks. Three asynchronous-peripheral strobes follow the first peripheral's tick. A sub-divider counts strobes of the third asynchronous domain. A timer divider counts ticks of the first peripheral and always divides by at least three.

A small write port holds the disable mask and the ratio fields. A status vector shows which domains are running. An error flag reports when the first two peripheral rates are not in an integer ratio.

Every divider is an instance of one two-state machine:
- In state `DV_FIRE`, the next input tick produces an output tick. On that tick the machine samples the ratio field. A ratio of 1 keeps it in `DV_FIRE` (transition *reload-fire*). A larger ratio moves it to `DV_WAIT` with a countdown loaded (transition *arm*).
- In `DV_WAIT`, each input tick decrements the countdown (transition *count*). When the countdown is already zero, the next input tick returns the machine to `DV_FIRE` (transition *expire*).
- Reset puts every divider in `DV_FIRE`.

Top module: `clk_enable_tree`

## Requirements
- R1: After reset, every domain is enabled (`running` = 10'h3FF) and `ratio_err` is low. The default ratios are: host 1, peripherals 1, sub-divider 2, timer 3, self-test 1. The delayed main strobe is low while reset is asserted.
- R2: With `st_mode` low, `en_main` is high on every cycle. With `st_mode` high, `en_main` is high once every S cycles, where S = field + 1 and the field is write-address 2, bits [7:5] (S from 1 to 8).
- R3: `en_main_dly` equals `en_main` exactly two reference cycles earlier. It therefore has the same rate as `en_main` and stops together with it.
- R4: The host divider counts main ticks and fires on every H-th one. H = field + 1, and the field is write-address 1, bits [1:0] (H from 1 to 4).
- R5: Peripheral divider k (k = 0, 1, 2) counts host ticks and fires on every P-th one. P = field + 1, and the field is write-address 1, bits [2+4k+3 : 2+4k] (P from 1 to 16). Peripheral k drives `en_per[k]`.
- R6: A write to address 0 loads the disable mask. A set bit holds the domain's strobe low from the next cycle on. The bit positions are:
  - bit 0: main and delayed main
  - bit 1: host
  - bit 2: peripheral 0
  - bit 3: peripheral 1
  - bit 8: peripheral 2
  - bits 4, 5, 11: asynchronous domains 0, 1, 2
  - bit 6: timer
  - bit 12: sub-divider
- R7: Disabling a domain does not stop its parent or its siblings. Child dividers keep counting the parent's ungated tick.
- R8: Each asynchronous strobe `en_asy[j]` follows the tick of peripheral 0, gated by its own disable bit.
- R9: The sub-divider counts `en_asy[2]` strobes and fires on every U-th one. U = field + 1, and the field is write-address 2, bits [2:0]. Its own disable bit has an effect only while asynchronous domain 2 runs. When that parent is disabled, `en_asy_sub` stays low and `running[8]` is low whatever the value of bit 12.
- R10: The timer counts peripheral-0 ticks and fires on every T-th one. T = field + 3, and the field is write-address 2, bits [4:3]. The timer strobe is therefore never more frequent than one third of the peripheral-0 tick rate.
- R11: `ratio_err` is high while (peripheral-0 ratio mod peripheral-1 ratio) is not zero. This is the case where the rate of peripheral 1 is not an integer multiple of the rate of peripheral 0.
- R12: A new ratio takes effect only at the affected divider's next firing tick. The period in progress completes at the old ratio.
- R13: `running` reports one bit per domain, set while the domain is enabled. The bit order is: 0 main, 1 host, 2–4 peripherals 0–2, 5–7 asynchronous 0–2, 8 sub-divider, 9 timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_mode | input | 1 | Self-test mode: divide the main strobe |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Configuration address (0 mask, 1 ratios, 2 auxiliary ratios) |
| cfg_wdata | input | 14 | Configuration write data |
| en_main | output | 1 | Main-domain strobe |
| en_main_dly | output | 1 | Main strobe delayed by two cycles |
| en_host | output | 1 | Host-domain strobe |
| en_per | output | 3 | Peripheral-domain strobes |
| en_asy | output | 3 | Asynchronous-peripheral strobes |
| en_asy_sub | output | 1 | Sub-divided strobe of asynchronous domain 2 |
| en_tmr | output | 1 | Timer-domain strobe |
| running | output | 10 | Per-domain enabled status |
| ratio_err | output | 1 | Peripheral ratio rule violated |

## Verification
The assertions check these properties on every cycle:
- The two-cycle lag of the delayed main strobe.
- The minimum three-cycle spacing of timer strobes.
- The gap that follows every divider firing at a ratio above one.
- The silence of the host strobe right after its mask bit is written.

Only the bench scenarios can show the behaviours that need a whole configuration history: exact rates over long windows for each ratio setting, parents continuing while children are off, the sub-divider's dependence on its parent, the error flag for particular ratio pairs, and the old period completing before a new ratio applies.

// File: rtl/cen_pkg.sv
package cen_pkg;

    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 14;
    localparam int NDOM    = 10;
    localparam int NPER    = 3;
    localparam int NASY    = 3;
    localparam int HOST_W  = 2;
    localparam int PER_W   = 4;
    localparam int SUB_W   = 3;
    localparam int TMR_W   = 2;
    localparam int ST_W    = 3;
    localparam int SUB_DEF = 1;
    localparam int TMR_MIN = 3;

    localparam logic [ADDR_W-1:0] A_MASK  = 2'd0;
    localparam logic [ADDR_W-1:0] A_RATIO = 2'd1;
    localparam logic [ADDR_W-1:0] A_AUX   = 2'd2;

    // domain indices, also the status bit order
    localparam int D_MAIN = 0;
    localparam int D_HOST = 1;
    localparam int D_PER0 = 2;
    localparam int D_ASY0 = 5;
    localparam int D_SUB  = 8;
    localparam int D_TMR  = 9;

    // position of each domain's disable bit in the mask word
    function automatic int mask_pos(input int d);
        case (d)
            0:       return 0;
            1:       return 1;
            2:       return 2;
            3:       return 3;
            4:       return 8;
            5:       return 4;
            6:       return 5;
            7:       return 11;
            8:       return 12;
            default: return 6;
        endcase
    endfunction

    typedef struct packed {
        logic [NDOM-1:0]            off;
        logic [HOST_W-1:0]          host_m1;
        logic [NPER-1:0][PER_W-1:0] per_m1;
        logic [SUB_W-1:0]           sub_m1;
        logic [TMR_W-1:0]           tmr_f;
        logic [ST_W-1:0]            st_m1;
    } cen_cfg_t;

endpackage

// File: rtl/cen_regs.sv
module cen_regs
    import cen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cen_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            cfg.sub_m1 <= SUB_W'(SUB_DEF);
        end else if (we) begin
            case (addr)
                A_MASK: begin
                    for (int d = 0; d < NDOM; d++)
                        cfg.off[d] <= wdata[mask_pos(d)];
                end
                A_RATIO: begin
                    cfg.host_m1 <= wdata[HOST_W-1:0];
                    for (int i = 0; i < NPER; i++)
                        cfg.per_m1[i] <= wdata[HOST_W + i*PER_W +: PER_W];
                end
                A_AUX: begin
                    cfg.sub_m1 <= wdata[SUB_W-1:0];
                    cfg.tmr_f  <= wdata[SUB_W +: TMR_W];
                    cfg.st_m1  <= wdata[SUB_W+TMR_W +: ST_W];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cen_div.sv
module cen_div #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_in,
    input  logic [RW-1:0] ratio_m1,
    output logic          tick_out
);

    typedef enum logic {DV_FIRE, DV_WAIT} dv_state_t;

    dv_state_t     state;
    logic [RW-1:0] remain;

    // state register: advances only on parent ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DV_FIRE;
            remain <= '0;
        end else if (tick_in) begin
            unique case (state)
                DV_FIRE: begin
                    if (ratio_m1 != '0) begin
                        state  <= DV_WAIT;
                        remain <= ratio_m1 - RW'(1);
                    end
                end
                DV_WAIT: begin
                    if (remain == '0) state  <= DV_FIRE;
                    else              remain <= remain - RW'(1);
                end
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            DV_FIRE: tick_out = tick_in;
            DV_WAIT: tick_out = 1'b0;
        endcase
    end

    // R12
    div_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_out && ratio_m1 != '0) |=> !tick_out);

endmodule

// File: rtl/clk_enable_tree.sv
module clk_enable_tree
    import cen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_mode,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [13:0]       cfg_wdata,
    output logic              en_main,
    output logic              en_main_dly,
    output logic              en_host,
    output logic [2:0]        en_per,
    output logic [2:0]        en_asy,
    output logic              en_asy_sub,
    output logic              en_tmr,
    output logic [9:0]        running,
    output logic              ratio_err
);

    localparam int TRW = TMR_W + 1;

    cen_cfg_t        cfg;
    logic            main_raw, host_raw, sub_raw, tmr_raw;
    logic [NPER-1:0] per_raw;
    logic [1:0]      dly_sr;
    logic [ST_W-1:0] main_m1;
    logic [TRW-1:0]  tmr_m1;
    logic [PER_W:0]  r_p0, r_p1;
    logic [1:0]      age;

    cen_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    assign main_m1 = st_mode ? cfg.st_m1 : '0;
    assign tmr_m1  = TRW'(cfg.tmr_f) + TRW'(TMR_MIN - 1);

    cen_div #(.RW(ST_W)) u_main (
        .clk(clk), .rst_n(rst_n), .tick_in(1'b1),
        .ratio_m1(main_m1), .tick_out(main_raw));

    cen_div #(.RW(HOST_W)) u_host (
        .clk(clk), .rst_n(rst_n), .tick_in(main_raw),
        .ratio_m1(cfg.host_m1), .tick_out(host_raw));

    for (genvar k = 0; k < NPER; k++) begin : g_per
        cen_div #(.RW(PER_W)) u_per (
            .clk(clk), .rst_n(rst_n), .tick_in(host_raw),
            .ratio_m1(cfg.per_m1[k]), .tick_out(per_raw[k]));
        assign en_per[k] = per_raw[k] & ~cfg.off[D_PER0+k];
    end

    for (genvar j = 0; j < NASY; j++) begin : g_asy
        assign en_asy[j] = per_raw[0] & ~cfg.off[D_ASY0+j];
    end

    cen_div #(.RW(SUB_W)) u_sub (
        .clk(clk), .rst_n(rst_n), .tick_in(en_asy[NASY-1]),
        .ratio_m1(cfg.sub_m1), .tick_out(sub_raw));

    cen_div #(.RW(TRW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick_in(per_raw[0]),
        .ratio_m1(tmr_m1), .tick_out(tmr_raw));

    assign en_main    = main_raw & ~cfg.off[D_MAIN];
    assign en_host    = host_raw & ~cfg.off[D_HOST];
    assign en_asy_sub = sub_raw  & ~cfg.off[D_SUB];
    assign en_tmr     = tmr_raw  & ~cfg.off[D_TMR];

    always_ff @(posedge clk) begin
        if (!rst_n) dly_sr <= '0;
        else        dly_sr <= {dly_sr[0], en_main};
    end
    assign en_main_dly = dly_sr[1];

    always_comb begin
        for (int d = 0; d < NDOM; d++) running[d] = ~cfg.off[d];
        running[D_SUB] = ~cfg.off[D_SUB] & ~cfg.off[D_ASY0+NASY-1];
    end

    assign r_p0      = (PER_W+1)'(cfg.per_m1[0]) + (PER_W+1)'(1);
    assign r_p1      = (PER_W+1)'(cfg.per_m1[1]) + (PER_W+1)'(1);
    assign ratio_err = (r_p0 % r_p1) != '0;

    // cycles since reset, saturating; used only by the checks below
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != '1) age <= age + 2'd1;
    end

    // R3
    dly_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (en_main_dly == $past(en_main, 2)));

    // R6
    host_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == A_MASK && cfg_wdata[1]) |=> !en_host);

    // R10
    tmr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && en_tmr) |-> (!$past(en_tmr) && !$past(en_tmr, 2)));

endmodule

// File: tb/tb_clk_enable_tree.sv
`timescale 1ns/1ps
module tb_clk_enable_tree;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [13:0] cfg_wdata = '0;
    logic        en_main, en_main_dly, en_host, en_asy_sub, en_tmr, ratio_err;
    logic [2:0]  en_per, en_asy;
    logic [9:0]  running;

    int checks = 0;
    int errors = 0;
    int cnt [11];

    always #4 clk = ~clk;

    clk_enable_tree dut (
        .clk(clk), .rst_n(rst_n), .st_mode(st_mode),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .en_main(en_main), .en_main_dly(en_main_dly), .en_host(en_host),
        .en_per(en_per), .en_asy(en_asy), .en_asy_sub(en_asy_sub),
        .en_tmr(en_tmr), .running(running), .ratio_err(ratio_err));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 14'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // index: 0 main,1 dly,2 host,3-5 per,6-8 asy,9 sub,10 tmr
    task automatic measure(input int n);
        foreach (cnt[i]) cnt[i] = 0;
        repeat (n) begin
            @(negedge clk);
            cnt[0] += int'(en_main);  cnt[1] += int'(en_main_dly);
            cnt[2] += int'(en_host);
            for (int k = 0; k < 3; k++) begin
                cnt[3+k] += int'(en_per[k]);
                cnt[6+k] += int'(en_asy[k]);
            end
            cnt[9] += int'(en_asy_sub); cnt[10] += int'(en_tmr);
        end
    endtask

    task automatic restore();
        st_mode = 1'b0;
        wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 1);
        settle(300);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        settle(4);
        chk("R1 running during reset", int'(running), 10'h3FF);
        chk("R1 ratio_err at reset", int'(ratio_err), 0);
        chk("R1 delayed strobe in reset", int'(en_main_dly), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_defaults();
        settle(20);
        measure(120);
        chk("R2 main every cycle", cnt[0], 120);
        chk("R3 delayed rate", cnt[1], 120);
        chk("R4 host default", cnt[2], 120);
        chk("R5 per0 default", cnt[3], 120);
        chk("R8 asy0 default", cnt[6], 120);
        chk("R9 sub default ratio 2", cnt[9], 60);
        chk("R10 timer default ratio 3", cnt[10], 40);
    endtask

    task automatic t_cascade();
        wr(2'd1, 1 | (2 << 2) | (2 << 6) | (3 << 10));
        settle(300);
        measure(720);
        chk("R4 host ratio 2", cnt[2], 360);
        chk("R5 per0 ratio 3", cnt[3], 120);
        chk("R5 per1 ratio 3", cnt[4], 120);
        chk("R5 per2 ratio 4", cnt[5], 90);
        chk("R8 asy2 follows per0", cnt[8], 120);
        chk("R10 timer of per0", cnt[10], 40);
        chk("R11 no error 3/3", int'(ratio_err), 0);
        restore();
    endtask

    task automatic t_ratio_err();
        wr(2'd1, (3 << 2) | (2 << 6));
        chk("R11 error 4 mod 3", int'(ratio_err), 1);
        wr(2'd1, (3 << 2) | (1 << 6));
        chk("R11 ok 4 mod 2", int'(ratio_err), 0);
        wr(2'd1, (3 << 2) | (7 << 6));
        chk("R11 error 4 mod 8", int'(ratio_err), 1);
        restore();
    endtask

    task automatic t_disable();
        wr(2'd0, 'h002); settle(4); measure(120);
        chk("R6 host off", cnt[2], 0);
        chk("R7 per0 continues", cnt[3], 120);
        chk("R13 running host bit", int'(running), 10'h3FD);
        wr(2'd0, 'h001); settle(4); measure(120);
        chk("R6 main off", cnt[0], 0);
        chk("R3 delayed off with main", cnt[1], 0);
        chk("R7 host continues", cnt[2], 120);
        chk("R13 running main bit", int'(running), 10'h3FE);
        wr(2'd0, 'h008); settle(4); measure(120);
        chk("R6 per1 off", cnt[4], 0);
        chk("R7 per2 sibling", cnt[5], 120);
        wr(2'd0, 'h100); settle(4); measure(120);
        chk("R6 per2 off at bit 8", cnt[5], 0);
        chk("R13 running per2 bit", int'(running), 10'h3EF);
        wr(2'd0, 'h010); settle(4); measure(120);
        chk("R8 asy0 off", cnt[6], 0);
        chk("R8 asy1 on", cnt[7], 120);
        wr(2'd0, 'h040); settle(4); measure(120);
        chk("R6 timer off at bit 6", cnt[10], 0);
        chk("R13 running timer bit", int'(running), 10'h1FF);
        restore();
    endtask

    task automatic t_sub_timer();
        wr(2'd2, 7 | (3 << 3));
        settle(100); measure(240);
        chk("R9 sub ratio 8", cnt[9], 30);
        chk("R10 timer ratio 6", cnt[10], 40);
        wr(2'd0, 'h1000); settle(10); measure(240);
        chk("R9 sub own disable", cnt[9], 0);
        chk("R9 asy2 still on", cnt[8], 240);
        chk("R13 running sub bit", int'(running[8]), 0);
        wr(2'd0, 'h800); settle(10); measure(240);
        chk("R9 asy2 off", cnt[8], 0);
        chk("R9 sub silent with parent off", cnt[9], 0);
        chk("R9 running sub follows parent", int'(running[8]), 0);
        chk("R13 running asy2 bit", int'(running[7]), 0);
        restore();
    endtask

    task automatic t_selftest();
        int bad;
        logic h1, h2;
        wr(2'd2, (2 << 5) | 1);
        st_mode = 1'b1;
        settle(100); measure(720);
        chk("R2 self-test ratio 3", cnt[0], 240);
        chk("R3 delayed self-test", cnt[1], 240);
        chk("R4 host of divided main", cnt[2], 240);
        chk("R10 timer in self-test", cnt[10], 80);
        bad = 0; h1 = en_main; h2 = 1'b0;
        @(negedge clk);
        h2 = h1; h1 = en_main;
        repeat (60) begin
            @(negedge clk);
            if (en_main_dly != h2) bad++;
            h2 = h1; h1 = en_main;
        end
        chk("R3 two-cycle lag", bad, 0);
        wr(2'd2, (7 << 5) | 1);
        settle(100); measure(720);
        chk("R2 self-test ratio 8", cnt[0], 90);
        restore();
    endtask

    task automatic t_terminal();
        int g;
        wr(2'd1, 7 << 2);
        settle(40);
        g = 0;
        while (!en_per[0] && g < 40) begin @(negedge clk); g++; end
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_wdata = 14'(1 << 2);
        g = 0;
        do begin @(negedge clk); cfg_we = 1'b0; g++; end
        while (!en_per[0] && g < 40);
        chk("R12 old period completes", g, 8);
        g = 0;
        do begin @(negedge clk); g++; end
        while (!en_per[0] && g < 40);
        chk("R12 new period applies", g, 2);
        restore();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_cascade();
        t_ratio_err();
        t_disable();
        t_sub_timer();
        t_selftest();
        t_terminal();
        summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got 1 expected 0");
        summary();
        $finish;
    end

endmodule